// File: doc/BRIEF.md
# Wrapping Context Stack Engine

This block saves and restores a processor's machine context on a small hardware stack. The stack lives in a fixed 64-byte window of a 13-bit address space. A 6-bit pointer selects the byte inside that window. A one-cycle start strobe picks the frame kind: a subroutine call or return moves the two bytes of the return address, and an interrupt entry or interrupt return moves five bytes (the program counter in two bytes, the index register, the accumulator and the condition codes). The block moves one byte per clock through a byte-wide memory port with asynchronous read data. It raises a one-cycle completion pulse after the last byte.

The pointer runs downward on pushes and upward on pulls. It wraps silently at both ends of the window, so a stack that runs too deep overwrites its oldest bytes and gives no warning. A separate strobe reloads the pointer to the top of the window. The restored register values stay on their outputs until a later pull overwrites them.

Top module: `ctx_stack_engine`

## Requirements
- R1: After the synchronous reset the pointer is 6'h3F, `mem_we` and `done` are 0, and all restored outputs are 0. The first push after reset writes at address 13'h007F.
- R2: Every stack access uses address bits [12:6] = 7'b0000001 and address bits [5:0] = the pointer value, or for a pull the incremented pointer.
- R3: A push cycle asserts `mem_we`, writes at the current pointer, and decrements the pointer at the clock edge. One byte is moved per clock with no idle cycle between bytes.
- R4: A pull cycle increments the pointer and reads at the incremented address in the same cycle, with `mem_we` low.
- R5: Interrupt entry (`int_enter`) writes PCL, PCH, X, A, CC in that order. Interrupt return (`int_return`) reads CC, A, X, PCH, PCL and drives them onto `cc_out`, `a_out`, `x_out` and `pc_out`.
- R6: A call (`sub_call`) writes PCL then PCH. A return (`sub_ret`) reads PCH then PCL into `pc_out`.
- R7: The PCH byte is written as {3'b000, pc[12:8]}. On a pull, only bits [4:0] of the PCH byte are loaded into `pc_out[12:8]`.
- R8: Decrementing from pointer 6'h00 gives 6'h3F, and incrementing from 6'h3F gives 6'h00. Neither case raises any flag.
- R9: When idle, `ptr_init` reloads the pointer to 6'h3F. If a start strobe arrives in the same cycle, `ptr_init` wins and the start is dropped.
- R10: `done` is high for exactly one cycle: the cycle after the clock edge that ends the last byte transfer of a frame.
- R11: While a frame is in progress, any start strobe and `ptr_init` are ignored. The frame completes unchanged, and no extra transfer follows it.
- R12: If several start strobes arrive together while idle, one frame is run, with priority interrupt entry > call > interrupt return > return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sub_call | input | 1 | Start a two-byte call push |
| sub_ret | input | 1 | Start a two-byte return pull |
| int_enter | input | 1 | Start a five-byte interrupt push |
| int_return | input | 1 | Start a five-byte interrupt pull |
| ptr_init | input | 1 | Reload the pointer to the top of the window |
| pc_in | input | 13 | Program counter to save (sampled with the start strobe) |
| x_in | input | 8 | Index register to save |
| a_in | input | 8 | Accumulator to save |
| cc_in | input | 8 | Condition codes to save |
| mem_rdata | input | 8 | Memory read data (valid in the same cycle as mem_addr) |
| mem_addr | output | 13 | Stack memory address |
| mem_wdata | output | 8 | Stack memory write data |
| mem_we | output | 1 | Stack memory write enable |
| pc_out | output | 13 | Restored program counter |
| x_out | output | 8 | Restored index register |
| a_out | output | 8 | Restored accumulator |
| cc_out | output | 8 | Restored condition codes |
| done | output | 1 | One-cycle frame completion pulse |

## Verification
Three kinds of cycle collision get directed tests. In the first, a pointer reload and an interrupt start are driven in the same idle cycle. The test checks that no write follows and that the next call writes at the top of the window. In the second, a call strobe, a return strobe and a reload are injected in the middle of a five-byte frame. The test checks the address and data of every remaining byte, and checks that `mem_we` is low once `done` fires. In the third, two start strobes arrive together, and the byte order written must be the interrupt order.

// File: rtl/ctx_stack_pkg.sv
package ctx_stack_pkg;

    localparam int ADDR_W  = 13;
    localparam int PTR_W   = 6;
    localparam int DATA_W  = 8;
    localparam int PC_W    = 13;
    localparam int STEP_W  = 3;
    localparam int PCH_W   = PC_W - DATA_W;
    localparam logic [ADDR_W-1:0] STACK_BASE = 13'h0040;
    localparam logic [ADDR_W-PTR_W-1:0] WIN_PREFIX = STACK_BASE[ADDR_W-1:PTR_W];

    typedef enum logic [1:0] {
        OP_CALL = 2'd0,
        OP_RET  = 2'd1,
        OP_IRQ  = 2'd2,
        OP_IRET = 2'd3
    } frame_op_e;

    // Position of each context byte within the push order.
    typedef enum logic [STEP_W-1:0] {
        SLOT_PCL = 3'd0,
        SLOT_PCH = 3'd1,
        SLOT_X   = 3'd2,
        SLOT_A   = 3'd3,
        SLOT_CC  = 3'd4
    } slot_e;

    typedef struct packed {
        logic [PC_W-1:0]   pc;
        logic [DATA_W-1:0] x;
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] cc;
    } ctx_t;

    function automatic logic [STEP_W-1:0] frame_len(frame_op_e op);
        return (op == OP_CALL || op == OP_RET) ? 3'd2 : 3'd5;
    endfunction

    function automatic logic is_push(frame_op_e op);
        return (op == OP_CALL || op == OP_IRQ);
    endfunction

    // Pushes walk the slots upward, pulls walk them back down.
    function automatic slot_e slot_at(frame_op_e op, logic [STEP_W-1:0] step);
        logic [STEP_W-1:0] idx;
        idx = is_push(op) ? step : (frame_len(op) - step - 3'd1);
        return slot_e'(idx);
    endfunction

endpackage

// File: rtl/ctx_sp_reg.sv
module ctx_sp_reg
    import ctx_stack_pkg::*;
#(
    parameter int P_W = PTR_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load_top,
    input  logic           dec,
    input  logic           inc,
    output logic [P_W-1:0] sp
);

    always_ff @(posedge clk) begin
        if (rst || load_top) begin
            sp <= '1;
        end else if (dec) begin
            sp <= sp - 1'b1;
        end else if (inc) begin
            sp <= sp + 1'b1;
        end
    end

    // R9: a reload leaves the pointer at the top of the window
    a_r9_load_top: assert property (@(posedge clk) disable iff (rst)
        load_top |=> (sp == '1));

    // R3: a push step lowers the pointer by one
    a_r3_push_dec: assert property (@(posedge clk) disable iff (rst)
        (dec && !load_top) |=> (sp == P_W'($past(sp) - 1'b1)));

    // R8: the bottom of the window wraps to the top
    a_r8_wrap_down: assert property (@(posedge clk) disable iff (rst)
        (dec && !load_top && sp == '0) |=> (sp == '1));

    // R8: the top of the window wraps to the bottom on a pull
    a_r8_wrap_up: assert property (@(posedge clk) disable iff (rst)
        (inc && !dec && !load_top && sp == '1) |=> (sp == '0));

endmodule

// File: rtl/ctx_frame_seq.sv
module ctx_frame_seq
    import ctx_stack_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sub_call,
    input  logic              sub_ret,
    input  logic              int_enter,
    input  logic              int_return,
    input  logic              ptr_init,
    output logic              busy,
    output logic              start,
    output logic              load_top,
    output frame_op_e         op,
    output logic [STEP_W-1:0] step,
    output logic              done
);

    frame_op_e op_sel;
    logic      any_go;
    logic      last;

    always_comb begin
        any_go   = sub_call | sub_ret | int_enter | int_return;
        load_top = !busy && ptr_init;
        start    = !busy && !ptr_init && any_go;
        // R12: fixed priority among simultaneous start strobes
        if (int_enter)      op_sel = OP_IRQ;
        else if (sub_call)  op_sel = OP_CALL;
        else if (int_return) op_sel = OP_IRET;
        else                op_sel = OP_RET;
        last = busy && (step == frame_len(op) - 3'd1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            op   <= OP_CALL;
            step <= '0;
            done <= 1'b0;
        end else begin
            done <= last;
            if (start) begin
                busy <= 1'b1;
                op   <= op_sel;
                step <= '0;
            end else if (busy) begin
                if (last) begin
                    busy <= 1'b0;
                    step <= '0;
                end else begin
                    step <= step + 1'b1;
                end
            end
        end
    end

    // R1: reset leaves the sequencer idle
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!busy && !done));

    // R10: completion is a single-cycle pulse
    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10: completion follows the last transfer
    a_r10_done_after_last: assert property (@(posedge clk) disable iff (rst)
        (busy && last) |=> (done && !busy));

    // R11: a frame in flight is neither restarted nor cut short
    a_r11_no_restart: assert property (@(posedge clk) disable iff (rst)
        (busy && !last) |=> (busy && op == $past(op) && step == STEP_W'($past(step) + 1'b1)));

    // R9: a reload in an idle cycle starts no frame
    a_r9_reload_wins: assert property (@(posedge clk) disable iff (rst)
        (!busy && ptr_init) |=> !busy);

endmodule

// File: rtl/ctx_stack_engine.sv
module ctx_stack_engine
    import ctx_stack_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sub_call,
    input  logic              sub_ret,
    input  logic              int_enter,
    input  logic              int_return,
    input  logic              ptr_init,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [DATA_W-1:0] x_in,
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] cc_in,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic [PC_W-1:0]   pc_out,
    output logic [DATA_W-1:0] x_out,
    output logic [DATA_W-1:0] a_out,
    output logic [DATA_W-1:0] cc_out,
    output logic              done
);

    logic              busy, start, load_top;
    frame_op_e         op;
    logic [STEP_W-1:0] step;
    logic [PTR_W-1:0]  sp, sp_up;
    logic              push, dec, inc;
    slot_e             slot;
    ctx_t              snap;
    logic [DATA_W-1:0] push_byte;

    ctx_frame_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .sub_call   (sub_call),
        .sub_ret    (sub_ret),
        .int_enter  (int_enter),
        .int_return (int_return),
        .ptr_init   (ptr_init),
        .busy       (busy),
        .start      (start),
        .load_top   (load_top),
        .op         (op),
        .step       (step),
        .done       (done)
    );

    ctx_sp_reg #(.P_W(PTR_W)) u_sp (
        .clk      (clk),
        .rst      (rst),
        .load_top (load_top),
        .dec      (dec),
        .inc      (inc),
        .sp       (sp)
    );

    // Context snapshot taken with the start strobe
    always_ff @(posedge clk) begin
        if (rst) begin
            snap <= '0;
        end else if (start) begin
            snap <= '{pc: pc_in, x: x_in, a: a_in, cc: cc_in};
        end
    end

    always_comb begin
        push  = is_push(op);
        dec   = busy && push;
        inc   = busy && !push;
        sp_up = sp + 1'b1;
        slot  = slot_at(op, step);
        unique case (slot)
            SLOT_PCL: push_byte = snap.pc[DATA_W-1:0];
            SLOT_PCH: push_byte = {{(DATA_W-PCH_W){1'b0}}, snap.pc[PC_W-1:DATA_W]};
            SLOT_X:   push_byte = snap.x;
            SLOT_A:   push_byte = snap.a;
            default:  push_byte = snap.cc;
        endcase
        mem_we    = dec;
        mem_wdata = dec ? push_byte : '0;
        mem_addr  = {WIN_PREFIX, (push ? sp : sp_up)};
    end

    // Restored context, loaded byte by byte as pulls proceed
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_out <= '0;
            x_out  <= '0;
            a_out  <= '0;
            cc_out <= '0;
        end else if (inc) begin
            unique case (slot)
                SLOT_PCL: pc_out[DATA_W-1:0]    <= mem_rdata;
                SLOT_PCH: pc_out[PC_W-1:DATA_W] <= mem_rdata[PCH_W-1:0];
                SLOT_X:   x_out                 <= mem_rdata;
                SLOT_A:   a_out                 <= mem_rdata;
                default:  cc_out                <= mem_rdata;
            endcase
        end
    end

    // R2: writes land in the window at the pointer
    a_r2_addr_window: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_addr[ADDR_W-1:PTR_W] == WIN_PREFIX && mem_addr[PTR_W-1:0] == sp));

    // R4: a pull leaves the pointer at the address it read
    a_r4_pull_addr: assert property (@(posedge clk) disable iff (rst)
        (busy && !push) |=> (sp == $past(mem_addr[PTR_W-1:0])));

    // R7: the saved high program counter byte has zero upper bits
    a_r7_pch_zero: assert property (@(posedge clk) disable iff (rst)
        (mem_we && slot == SLOT_PCH) |-> (mem_wdata[DATA_W-1:PCH_W] == '0));

    // R11: no write outside a frame
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        done |-> !mem_we);

endmodule

// File: tb/test_ctx_stack_engine.sv
`timescale 1ns/1ps
module test_ctx_stack_engine;

    localparam logic [1:0] K_CALL = 2'd0, K_RET = 2'd1, K_IRQ = 2'd2, K_IRET = 2'd3;

    // {kind, pc, x, a, cc}: stimulus for pushes, expected restore for pulls
    localparam logic [38:0] VEC [10] = '{
        {K_IRQ,  13'h1234, 8'h11, 8'h22, 8'h0A},
        {K_CALL, 13'h0ABC, 8'h00, 8'h00, 8'h00},
        {K_CALL, 13'h1FFF, 8'h00, 8'h00, 8'h00},
        {K_RET,  13'h1FFF, 8'h00, 8'h00, 8'h00},
        {K_RET,  13'h0ABC, 8'h00, 8'h00, 8'h00},
        {K_IRET, 13'h1234, 8'h11, 8'h22, 8'h0A},
        {K_CALL, 13'h0F0F, 8'h00, 8'h00, 8'h00},
        {K_IRQ,  13'h0777, 8'hA5, 8'h5A, 8'h1F},
        {K_IRET, 13'h0777, 8'hA5, 8'h5A, 8'h1F},
        {K_RET,  13'h0F0F, 8'h00, 8'h00, 8'h00}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sub_call = 0, sub_ret = 0, int_enter = 0, int_return = 0, ptr_init = 0;
    logic [12:0] pc_in = '0;
    logic [7:0]  x_in = '0, a_in = '0, cc_in = '0;
    logic [7:0]  mem_rdata;
    logic [12:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic [12:0] pc_out;
    logic [7:0]  x_out, a_out, cc_out;
    logic        done;

    logic [7:0]  sram [64];
    logic [5:0]  sp_m;
    int          checks = 0;
    int          failures = 0;

    always #10 clk = ~clk;

    always @(posedge clk) if (mem_we) sram[mem_addr[5:0]] <= mem_wdata;
    assign mem_rdata = sram[mem_addr[5:0]];

    ctx_stack_engine i_ctx_stack_engine (
        .clk(clk), .rst(rst),
        .sub_call(sub_call), .sub_ret(sub_ret), .int_enter(int_enter), .int_return(int_return),
        .ptr_init(ptr_init), .pc_in(pc_in), .x_in(x_in), .a_in(a_in), .cc_in(cc_in),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .pc_out(pc_out), .x_out(x_out), .a_out(a_out), .cc_out(cc_out), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pbyte(int k, logic [12:0] pc, logic [7:0] x, logic [7:0] a, logic [7:0] cc);
        case (k)
            0:       return pc[7:0];
            1:       return {3'b000, pc[12:8]};
            2:       return x;
            3:       return a;
            default: return cc;
        endcase
    endfunction

    task automatic reload_ptr();
        @(negedge clk); ptr_init = 1;
        @(negedge clk); ptr_init = 0;
        sp_m = 6'h3F;
    endtask

    // Runs one frame and checks each byte; inj injects stray strobes at that step
    task automatic run_op(input logic [1:0] kind, input logic [12:0] pc, input logic [7:0] x,
                          input logic [7:0] a, input logic [7:0] cc, input int inj,
                          input bit both, input string tg);
        int len;
        bit push;
        string t_addr, t_data;
        len  = (kind == K_CALL || kind == K_RET) ? 2 : 5;
        push = (kind == K_CALL || kind == K_IRQ);
        t_addr = (tg != "") ? tg : (push ? "R3" : "R4");
        t_data = (tg != "") ? tg : ((len == 5) ? "R5" : "R6");
        @(negedge clk);
        sub_call   = (kind == K_CALL) || both;
        sub_ret    = (kind == K_RET);
        int_enter  = (kind == K_IRQ);
        int_return = (kind == K_IRET);
        pc_in = pc; x_in = x; a_in = a; cc_in = cc;
        @(negedge clk);
        sub_call = 0; sub_ret = 0; int_enter = 0; int_return = 0;
        pc_in = '0; x_in = '0; a_in = '0; cc_in = '0;
        for (int k = 0; k < len; k++) begin
            if (k == inj) begin
                sub_call = 1; sub_ret = 1; ptr_init = 1;
            end
            if (push) begin
                chk(mem_we === 1'b1, t_addr, {31'd0, mem_we}, 1);
                chk(mem_addr === {7'h01, sp_m}, t_addr, {19'd0, mem_addr}, {19'd0, 7'h01, sp_m});
                chk(mem_wdata === pbyte(k, pc, x, a, cc), t_data, {24'd0, mem_wdata},
                    {24'd0, pbyte(k, pc, x, a, cc)});
                sp_m = sp_m - 1'b1;
            end else begin
                sp_m = sp_m + 1'b1;
                chk(mem_we === 1'b0, t_addr, {31'd0, mem_we}, 0);
                chk(mem_addr === {7'h01, sp_m}, t_addr, {19'd0, mem_addr}, {19'd0, 7'h01, sp_m});
            end
            @(negedge clk);
            sub_call = 0; sub_ret = 0; ptr_init = 0;
        end
        chk(done === 1'b1, "R10", {31'd0, done}, 1);
        chk(mem_we === 1'b0, (inj >= 0) ? "R11" : "R10", {31'd0, mem_we}, 0);
        if (kind == K_RET) chk(pc_out === pc, (tg != "") ? tg : "R6", {19'd0, pc_out}, {19'd0, pc});
        if (kind == K_IRET) begin
            chk(pc_out === pc, t_data, {19'd0, pc_out}, {19'd0, pc});
            chk(x_out === x, t_data, {24'd0, x_out}, {24'd0, x});
            chk(a_out === a, t_data, {24'd0, a_out}, {24'd0, a});
            chk(cc_out === cc, t_data, {24'd0, cc_out}, {24'd0, cc});
        end
        @(negedge clk);
        chk(done === 1'b0, "R10", {31'd0, done}, 0);
        chk(mem_we === 1'b0, (inj >= 0) ? "R11" : "R10", {31'd0, mem_we}, 0);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(20 * 50000);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 64; i++) sram[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(mem_we === 1'b0 && done === 1'b0, "R1", {30'd0, mem_we, done}, 0);
        chk(pc_out === 13'd0 && x_out === 8'd0 && a_out === 8'd0 && cc_out === 8'd0, "R1",
            {19'd0, pc_out}, 0);
        sub_call = 1; pc_in = 13'h0101;
        @(negedge clk);
        sub_call = 0; pc_in = '0;
        chk(mem_addr[5:0] === 6'h3F, "R1", {26'd0, mem_addr[5:0]}, 32'h3F);
        chk(mem_addr[12:6] === 7'h01, "R2", {25'd0, mem_addr[12:6]}, 1);
        repeat (3) @(negedge clk);
        reload_ptr();

        // Vector table
        for (int v = 0; v < 10; v++) begin
            run_op(VEC[v][38:37], VEC[v][36:24], VEC[v][23:16], VEC[v][15:8], VEC[v][7:0], -1, 0, "");
        end

        // R9: reload and start collide; reload wins
        run_op(K_CALL, 13'h0042, 8'h0, 8'h0, 8'h0, -1, 0, "");
        @(negedge clk); ptr_init = 1; int_enter = 1;
        @(negedge clk); ptr_init = 0; int_enter = 0;
        chk(mem_we === 1'b0, "R9", {31'd0, mem_we}, 0);
        @(negedge clk);
        chk(mem_we === 1'b0 && done === 1'b0, "R9", {30'd0, mem_we, done}, 0);
        sp_m = 6'h3F;
        run_op(K_CALL, 13'h0155, 8'h0, 8'h0, 8'h0, -1, 0, "R9");

        // R11: strobes injected during a frame are ignored
        run_op(K_IRQ, 13'h1A2B, 8'h33, 8'h44, 8'h55, 2, 0, "R11");

        // R12: simultaneous starts pick the interrupt entry
        run_op(K_IRQ, 13'h0C0D, 8'h66, 8'h77, 8'h88, -1, 1, "R12");

        // R8: overflow wraps, then the newest frame still restores
        reload_ptr();
        for (int n = 0; n < 12; n++) run_op(K_IRQ, 13'(n), 8'(n), 8'(n + 1), 8'(n + 2), -1, 0, "");
        run_op(K_IRQ, 13'h1ACE, 8'hB1, 8'hB2, 8'hB3, -1, 0, "R8");
        run_op(K_IRET, 13'h1ACE, 8'hB1, 8'hB2, 8'hB3, -1, 0, "R8");

        // R7: pull from top wraps to bottom, PCH upper bits dropped
        reload_ptr();
        @(negedge clk);
        sram[0] = 8'hE5;
        sram[1] = 8'h3C;
        run_op(K_RET, 13'h053C, 8'h0, 8'h0, 8'h0, -1, 0, "R7");

        finish_run();
    end

endmodule